// File: doc/BRIEF.md
# RC Oscillator Trim Loop

This block keeps an on-chip 24 MHz RC oscillator on frequency by measuring it against a slow 32 kHz reference. It runs on the RC clock itself. The reference is brought into that domain through a synchroniser. The block counts RC cycles between consecutive reference rising edges and compares the count with a programmable target. Each reference period it moves an 8-bit trim code by at most one step. Two independent hysteresis margins, one above the target and one below it, set a dead band in which the trim stays where it is.

Software controls the loop through plain level inputs. These are a run/stop control, an update permit, a direction flip for trim hardware with the opposite slope, and a manual override that forces a programmed trim code. While the loop is stopped, the manual value also seeds the trim. A divider on the RC clock produces a roughly 1 MHz tick. The divider uses either the programmed divisor or a fixed build-time divisor. The block also raises a sticky flag when a reference period holds fewer RC cycles than the programmed divisor.

Top module: `rc_trim_loop`

## Requirements
- R1: While `rst` is high, and at the first sample after it, `trim_code`, `meas_count`, `err_flag` and `tick_1m` are all 0.
- R2: `meas_count` takes the number of `clk` cycles between the two most recent rising edges of `ref_in`. The first rising edge after the loop starts only arms the measurement. The value changes only on a rising edge.
- R3: With the flip control clear, the loop acts at each measuring edge when updates are permitted. A count greater than target plus `hyst_pos` lowers the trim by 1. A count for which count plus `hyst_neg` is below the target raises the trim by 1. Any other count leaves the trim unchanged.
- R4: With `ctl_invert` high, the raise and lower directions of R3 are exchanged.
- R5: The computed trim saturates at 0x00 and 0xFF and never wraps.
- R6: With `ctl_enable` low, the computed trim is held while `meas_count` keeps updating.
- R7: With `ctl_bypass` high, `trim_code` equals `man_trim` one cycle later. The computed trim keeps evolving underneath and shows again once the override is cleared.
- R8: With `ctl_start` low, the computed trim is loaded from `man_trim`, `meas_count` and `err_flag` are cleared, and the loop disarms.
- R9: When `mhz_enable` is high, `tick_1m` pulses once every D cycles. D is `mhz_target` when `mhz_sel_corr` is 1 (0 counts as 1) and the fixed divisor `UNCORR_DIV` when it is 0. With `mhz_enable` low, no pulse appears.
- R10: At a measuring edge with `mhz_enable` high and a count below `mhz_target`, `err_flag` sets and stays set. A high `err_clr` clears it, but a set in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RC oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | 32 kHz reference, asynchronous |
| ctl_start | input | 1 | Run (1) or stop and reset the loop (0) |
| ctl_enable | input | 1 | Permit trim updates |
| ctl_bypass | input | 1 | Force the output trim to the manual value |
| ctl_invert | input | 1 | Reverse the step direction |
| man_trim | input | 8 | Manual trim value and seed |
| hyst_pos | input | 4 | Margin above target |
| hyst_neg | input | 4 | Margin below target |
| tgt_count | input | 12 | Target RC cycles per reference period |
| mhz_target | input | 12 | Programmed 1 MHz divisor |
| mhz_enable | input | 1 | Enable the 1 MHz tick and its check |
| mhz_sel_corr | input | 1 | 1 selects the programmed divisor, 0 the fixed divisor |
| err_clr | input | 1 | Clear the error flag |
| trim_code | output | 8 | Trim code in use |
| meas_count | output | 12 | Last measured period count |
| err_flag | output | 1 | Sticky divisor-shortfall flag |
| tick_1m | output | 1 | 1 MHz tick pulse |

## Verification
The error flag's set condition and its clear input can land in the same cycle. That cycle is the one in which the synchronised reference edge is seen. The bench provokes the collision by raising `err_clr` for exactly that cycle, two clock edges after it drives the reference high, while the period count is below `mhz_target`. It passes only if the flag reads 1 afterwards. The same timing with a count at or above the target has to clear the flag, which shows that the clear was really applied in that cycle.

// File: rtl/rc_trim_pkg.sv
`timescale 1ns/1ps
package rc_trim_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

  function automatic step_e flip_step(input step_e s, input logic inv);
    step_e r;
    r = s;
    if (inv) begin
      case (s)
        STEP_UP:   r = STEP_DOWN;
        STEP_DOWN: r = STEP_UP;
        default:   r = s;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/rc_ref_sync.sv
`timescale 1ns/1ps
module rc_ref_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_i,
  output logic rise_o
);
  localparam int LAST = STAGES;

  logic [LAST:0] sh_q;

  genvar g;
  generate
    for (g = 0; g <= LAST; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sh_q[0] <= 1'b0;
          else     sh_q[0] <= ref_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sh_q[g] <= 1'b0;
          else     sh_q[g] <= sh_q[g-1];
        end
      end
    end
  endgenerate

  assign rise_o = sh_q[LAST-1] & ~sh_q[LAST];

endmodule

// File: rtl/rc_period_counter.sv
`timescale 1ns/1ps
module rc_period_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             rise_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] meas_o,
  output logic             stb_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] meas_q;
  logic             armed_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q   <= '0;
      meas_q  <= '0;
      armed_q <= 1'b0;
    end else if (rise_i) begin
      cnt_q   <= CNT_W'(1);
      armed_q <= 1'b1;
      if (armed_q) meas_q <= cnt_q;
    end else if (cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign meas_o = meas_q;
  assign stb_o  = run_i & rise_i & armed_q;

  p_meas_only_on_edge_r2: assert property (@(posedge clk) disable iff (rst)
    (run_i && !rise_i) |=> $stable(meas_q));

  p_stop_clears_meas_r8: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> (meas_q == '0));

endmodule

// File: rtl/rc_trim_stepper.sv
`timescale 1ns/1ps
module rc_trim_stepper
  import rc_trim_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int TRIM_W = 8,
  parameter int HYST_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_i,
  input  logic              en_i,
  input  logic              inv_i,
  input  logic              stb_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]  tgt_i,
  input  logic [HYST_W-1:0] hp_i,
  input  logic [HYST_W-1:0] hn_i,
  input  logic [TRIM_W-1:0] seed_i,
  output logic [TRIM_W-1:0] trim_o
);
  localparam int EXT_W = CNT_W + 1;
  localparam logic [TRIM_W-1:0] TRIM_MAX = '1;

  logic [EXT_W-1:0] cnt_x, tgt_x, upper_x, cnt_hn_x;
  step_e raw_step, dir_step;
  logic [TRIM_W-1:0] trim_q;

  assign cnt_x    = EXT_W'(cnt_i);
  assign tgt_x    = EXT_W'(tgt_i);
  assign upper_x  = tgt_x + EXT_W'(hp_i);
  assign cnt_hn_x = cnt_x + EXT_W'(hn_i);

  always_comb begin
    raw_step = STEP_HOLD;
    if (cnt_x > upper_x)        raw_step = STEP_DOWN;
    else if (cnt_hn_x < tgt_x)  raw_step = STEP_UP;
    dir_step = flip_step(raw_step, inv_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trim_q <= '0;
    end else if (!run_i) begin
      trim_q <= seed_i;
    end else if (stb_i && en_i) begin
      case (dir_step)
        STEP_UP:   if (trim_q != TRIM_MAX) trim_q <= trim_q + 1'b1;
        STEP_DOWN: if (trim_q != '0)       trim_q <= trim_q - 1'b1;
        default:   trim_q <= trim_q;
      endcase
    end
  end

  assign trim_o = trim_q;

  p_unit_step_r5: assert property (@(posedge clk) disable iff (rst)
    run_i |=> (trim_q == $past(trim_q)) ||
              ({1'b0, trim_q} == {1'b0, $past(trim_q)} + 1'b1) ||
              ({1'b0, $past(trim_q)} == {1'b0, trim_q} + 1'b1));

  p_hold_between_edges_r3: assert property (@(posedge clk) disable iff (rst)
    (run_i && !stb_i) |=> $stable(trim_q));

  p_hold_disabled_r6: assert property (@(posedge clk) disable iff (rst)
    (run_i && !en_i) |=> $stable(trim_q));

endmodule

// File: rtl/rc_mhz_monitor.sv
`timescale 1ns/1ps
module rc_mhz_monitor #(
  parameter int CNT_W      = 12,
  parameter int UNCORR_DIV = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             sel_i,
  input  logic [CNT_W-1:0] tgt_i,
  input  logic             run_i,
  input  logic             stb_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             clr_i,
  output logic             tick_o,
  output logic             err_o
);
  localparam logic [CNT_W-1:0] FIXED_DIV = CNT_W'(UNCORR_DIV);

  logic [CNT_W-1:0] div_w, lim_w, dcnt_q;
  logic             tick_q, err_q, wrap_w, short_w;

  assign div_w   = sel_i ? tgt_i : FIXED_DIV;
  assign lim_w   = (div_w == '0) ? '0 : div_w - 1'b1;
  assign wrap_w  = (dcnt_q >= lim_w);
  assign short_w = stb_i && en_i && (cnt_i < tgt_i);

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      dcnt_q <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= wrap_w;
      dcnt_q <= wrap_w ? '0 : dcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !run_i) err_q <= 1'b0;
    else if (short_w)  err_q <= 1'b1;
    else if (clr_i)    err_q <= 1'b0;
  end

  assign tick_o = tick_q;
  assign err_o  = err_q;

  p_quiet_when_off_r9: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !tick_q);

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (run_i && err_q && !clr_i) |=> err_q);

  p_err_stop_r8: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> !err_q);

endmodule

// File: rtl/rc_trim_loop.sv
`timescale 1ns/1ps
module rc_trim_loop #(
  parameter int CNT_W       = 12,
  parameter int TRIM_W      = 8,
  parameter int HYST_W      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int UNCORR_DIV  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_in,
  input  logic              ctl_start,
  input  logic              ctl_enable,
  input  logic              ctl_bypass,
  input  logic              ctl_invert,
  input  logic [TRIM_W-1:0] man_trim,
  input  logic [HYST_W-1:0] hyst_pos,
  input  logic [HYST_W-1:0] hyst_neg,
  input  logic [CNT_W-1:0]  tgt_count,
  input  logic [CNT_W-1:0]  mhz_target,
  input  logic              mhz_enable,
  input  logic              mhz_sel_corr,
  input  logic              err_clr,
  output logic [TRIM_W-1:0] trim_code,
  output logic [CNT_W-1:0]  meas_count,
  output logic              err_flag,
  output logic              tick_1m
);
  logic              rise_w, stb_w;
  logic [CNT_W-1:0]  cnt_w;
  logic [TRIM_W-1:0] calc_trim_w;
  logic [TRIM_W-1:0] trim_q;

  rc_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .ref_i(ref_in), .rise_o(rise_w)
  );

  rc_period_counter #(.CNT_W(CNT_W)) u_period (
    .clk(clk), .rst(rst), .run_i(ctl_start), .rise_i(rise_w),
    .cnt_o(cnt_w), .meas_o(meas_count), .stb_o(stb_w)
  );

  rc_trim_stepper #(.CNT_W(CNT_W), .TRIM_W(TRIM_W), .HYST_W(HYST_W)) u_step (
    .clk(clk), .rst(rst), .run_i(ctl_start), .en_i(ctl_enable),
    .inv_i(ctl_invert), .stb_i(stb_w), .cnt_i(cnt_w), .tgt_i(tgt_count),
    .hp_i(hyst_pos), .hn_i(hyst_neg), .seed_i(man_trim), .trim_o(calc_trim_w)
  );

  rc_mhz_monitor #(.CNT_W(CNT_W), .UNCORR_DIV(UNCORR_DIV)) u_mhz (
    .clk(clk), .rst(rst), .en_i(mhz_enable), .sel_i(mhz_sel_corr),
    .tgt_i(mhz_target), .run_i(ctl_start), .stb_i(stb_w), .cnt_i(cnt_w),
    .clr_i(err_clr), .tick_o(tick_1m), .err_o(err_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) trim_q <= '0;
    else     trim_q <= ctl_bypass ? man_trim : calc_trim_w;
  end

  assign trim_code = trim_q;

  p_bypass_follows_r7: assert property (@(posedge clk) disable iff (rst)
    ctl_bypass |=> (trim_q == $past(man_trim)));

endmodule

// File: tb/rc_trim_loop_bench.sv
`timescale 1ns/1ps
module rc_trim_loop_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ref_in = 1'b0;
  logic        ctl_start = 1'b0, ctl_enable = 1'b0, ctl_bypass = 1'b0, ctl_invert = 1'b0;
  logic [7:0]  man_trim = 8'h80;
  logic [3:0]  hyst_pos = 4'd3, hyst_neg = 4'd5;
  logic [11:0] tgt_count = 12'd100, mhz_target = 12'd0;
  logic        mhz_enable = 1'b0, mhz_sel_corr = 1'b0, err_clr = 1'b0;
  logic [7:0]  trim_code;
  logic [11:0] meas_count;
  logic        err_flag, tick_1m;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int m_trim, m_meas, m_err, m_last;
  bit m_armed;

  always #4 clk = ~clk;

  rc_trim_loop u_rc_trim_loop (
    .clk(clk), .rst(rst), .ref_in(ref_in), .ctl_start(ctl_start),
    .ctl_enable(ctl_enable), .ctl_bypass(ctl_bypass), .ctl_invert(ctl_invert),
    .man_trim(man_trim), .hyst_pos(hyst_pos), .hyst_neg(hyst_neg),
    .tgt_count(tgt_count), .mhz_target(mhz_target), .mhz_enable(mhz_enable),
    .mhz_sel_corr(mhz_sel_corr), .err_clr(err_clr), .trim_code(trim_code),
    .meas_count(meas_count), .err_flag(err_flag), .tick_1m(tick_1m)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int next_trim(input int t, input int gap);
    int d;
    d = 0;
    if (gap > int'(tgt_count) + int'(hyst_pos)) d = -1;
    else if (gap + int'(hyst_neg) < int'(tgt_count)) d = 1;
    if (ctl_invert) d = -d;
    t = t + d;
    if (t < 0) t = 0;
    if (t > 255) t = 255;
    return t;
  endfunction

  // One reference period of p cycles; mode 1 = clear on edge cycle, 2 = clear afterwards
  task automatic ref_period(input int p, input int mode, input string tag);
    bit short;
    ref_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    if (mode == 1) err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    repeat (3) @(negedge clk);
    if (m_armed) begin
      m_meas = m_last;
      if (ctl_enable) m_trim = next_trim(m_trim, m_last);
      short = mhz_enable && (m_last < int'(mhz_target));
      if (short) m_err = 1;
      else if (mode == 1) m_err = 0;
    end else begin
      m_armed = 1'b1;
      if (mode == 1) m_err = 0;
    end
    chk({tag, " trim"}, 32'(trim_code), 32'(ctl_bypass ? int'(man_trim) : m_trim));
    chk({tag, " R2 meas"}, 32'(meas_count), 32'(m_meas));
    chk({tag, " err"}, 32'(err_flag), 32'(m_err));
    if (mode == 2) begin
      err_clr = 1'b1;
      @(negedge clk);
      err_clr = 1'b0;
      m_err = 0;
      repeat (p / 2 - 7) @(negedge clk);
    end else begin
      repeat (p / 2 - 6) @(negedge clk);
    end
    ref_in = 1'b0;
    repeat (p - p / 2) @(negedge clk);
    m_last = p;
  endtask

  task automatic stop_restart(input logic [7:0] seed);
    ctl_start = 1'b0;
    man_trim  = seed;
    repeat (4) @(negedge clk);
    chk("R8 stop trim", 32'(trim_code), 32'(seed));
    chk("R8 stop meas", 32'(meas_count), 32'd0);
    chk("R8 stop err", 32'(err_flag), 32'd0);
    ctl_start = 1'b1;
    m_trim = seed; m_meas = 0; m_err = 0; m_armed = 1'b0;
  endtask

  task automatic tick_gap(output int g);
    int guard;
    g = -1;
    guard = 0;
    while (tick_1m !== 1'b1 && guard < 300) begin @(negedge clk); guard++; end
    if (guard >= 300) return;
    g = 0;
    do begin @(negedge clk); g++; end while (tick_1m !== 1'b1 && g < 300);
  endtask

  initial begin : watchdog
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    int g;
    int seen;
    repeat (5) @(negedge clk);
    chk("R1 reset trim", 32'(trim_code), 32'd0);
    chk("R1 reset meas", 32'(meas_count), 32'd0);
    chk("R1 reset err", 32'(err_flag), 32'd0);
    chk("R1 reset tick", 32'(tick_1m), 32'd0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 seed after reset", 32'(trim_code), 32'h80);

    ctl_enable = 1'b1;
    ctl_start  = 1'b1;
    m_trim = 8'h80; m_meas = 0; m_err = 0; m_armed = 1'b0; m_last = 0;
    ref_period(100, 0, "R2 arm");
    for (int p = 90; p <= 112; p++) ref_period(p, 0, "R3 sweep up");

    ctl_invert = 1'b1;
    for (int p = 112; p >= 88; p--) ref_period(p, 0, "R4 inverted sweep");
    ctl_invert = 1'b0;

    ctl_enable = 1'b0;
    for (int i = 0; i < 3; i++) ref_period(80 + 10 * i, 0, "R6 hold");
    ctl_enable = 1'b1;

    ctl_bypass = 1'b1;
    man_trim   = 8'h33;
    for (int i = 0; i < 3; i++) ref_period(80, 0, "R7 bypass");
    ctl_bypass = 1'b0;
    ref_period(80, 0, "R7 release");

    stop_restart(8'hFD);
    ref_period(60, 0, "R8 rearm");
    for (int i = 0; i < 5; i++) ref_period(60, 0, "R5 top clamp");
    chk("R5 top value", 32'(trim_code), 32'hFF);

    stop_restart(8'h02);
    ref_period(140, 0, "R8 rearm");
    for (int i = 0; i < 5; i++) ref_period(140, 0, "R5 bottom clamp");
    chk("R5 bottom value", 32'(trim_code), 32'h00);

    stop_restart(8'h80);
    mhz_enable = 1'b1;
    mhz_sel_corr = 1'b1;
    mhz_target = 12'd120;
    ref_period(100, 0, "R10 arm");
    ref_period(100, 2, "R10 set then clear");
    mhz_target = 12'd90;
    ref_period(100, 0, "R10 cleared stays");
    mhz_target = 12'd120;
    ref_period(100, 1, "R10 set wins over clear");
    ref_period(100, 0, "R10 sticky");
    mhz_target = 12'd90;
    ref_period(100, 1, "R10 clear on edge");

    mhz_target = 12'd10;
    repeat (30) @(negedge clk);
    tick_gap(g); chk("R9 corrected gap 10", 32'(g), 32'd10);
    mhz_target = 12'd7;
    repeat (30) @(negedge clk);
    tick_gap(g); chk("R9 corrected gap 7", 32'(g), 32'd7);
    mhz_target = 12'd0;
    repeat (10) @(negedge clk);
    tick_gap(g); chk("R9 zero divisor gap", 32'(g), 32'd1);
    mhz_sel_corr = 1'b0;
    repeat (60) @(negedge clk);
    tick_gap(g); chk("R9 fixed gap", 32'(g), 32'd24);
    mhz_enable = 1'b0;
    @(negedge clk);
    seen = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (tick_1m) seen++;
    end
    chk("R9 disabled ticks", 32'(seen), 32'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule